// File: doc/BRIEF.md
# Protected Boot-Mode Control Register

This block holds a small configuration register that decides which program memory bank a processor fetches from: a large main bank or a small loader bank. The register is normally locked. It accepts writes only after a separate key register has received a fixed two-byte unlock sequence. Setting the loader-request bit does not move execution at once. The bank select changes only when the processor next wakes from idle. The block then issues a one-cycle pulse that clears the program counter, so the loader starts at its first byte.

A write that sets three specific configuration bits together issues a one-cycle software reset. This reset acts like an external reset. It returns the register, the unlock state and the bank select to their power-on values, which puts execution back in the main bank. The block also turns the processor's program address into a physical address over the combined main and loader storage.

Top module: `boot_mode_ctrl`

## Requirements
- R1: After the synchronous reset, the configuration register reads 00h, the key status reads 0 and bank_sel is 0 (main bank). pc_clear and soft_rst are both 0.
- R2: A write to the configuration register (address 0) while the key status is 0 leaves the register unchanged. No reset pulse and no bank change follow from it.
- R3: Writing 87h and then 59h to the key register (address 1), as two key writes in a row, sets the key status. Writes to other addresses between them do not break the sequence. While the key status is 1, configuration writes are stored.
- R4: A key write of 87h restarts the sequence from any state, and it clears permission. A key write of 59h that does not directly follow 87h clears permission. Any other key value also clears permission.
- R5: Configuration bit 0 requests the loader bank. bank_sel does not follow it on the write itself, and it does not follow it on a wake pulse that had no idle pulse before it.
- R6: Take a wake pulse that comes after an idle pulse, with configuration bit 0 different from bank_sel. On the following cycle, bank_sel equals bit 0 and pc_clear is 1, for exactly one cycle. If bit 0 already equals bank_sel, pc_clear stays 0.
- R7: An unlocked configuration write with bits 0, 1 and 7 all set (mask 83h) gives soft_rst = 1 for exactly one cycle. In that same cycle the register reads 00h, the key status reads 0 and bank_sel is 0. A locked write of such a value gives no pulse.
- R8: One cycle after cpu_addr is presented, mem_addr is as follows. With bank_sel = 0 it is cpu_addr modulo 32768. With bank_sel = 1 it is 32768 + (cpu_addr modulo 4096).
- R9: One cycle after bus_addr is presented, rd_data is as follows. Address 0 returns the configuration register. Address 1 returns {7'b0, key status}. Any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| idle_in | input | 1 | Pulse: processor enters idle |
| wake_in | input | 1 | Pulse: processor wakes from idle |
| cpu_addr | input | 16 | Processor program address |
| mem_addr | output | 16 | Physical address over both banks |
| bank_sel | output | 1 | 0 main bank, 1 loader bank |
| pc_clear | output | 1 | One-cycle program-counter clear |
| soft_rst | output | 1 | One-cycle software reset |

## Verification
Every possible second key byte is tried after 87h. This shows that only 59h opens the register, and each case is checked through the key status and a test configuration write. Every possible configuration byte is written once while locked and once while unlocked. This separates the values that trigger a reset from those that are only stored. Short directed orderings then cover the restart behaviour: 87h after a wrong value, 59h without 87h, and a repeated 87h. Further orderings cover wake without idle, wake after idle with and without a bank change, and the return to the main bank by reset. A strided sweep of program addresses in both banks checks the address fold.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/boot_key_unlock.sv
module boot_key_unlock #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h87,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlocked
);
  import boot_pkg::*;

  key_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st_q <= KEY_LOCKED;
    end else if (key_we) begin
      if (key_data == KEY_FIRST)
        st_q <= KEY_HALF;
      else if (key_data == KEY_SECOND && st_q == KEY_HALF)
        st_q <= KEY_OPEN;
      else
        st_q <= KEY_LOCKED;
    end
  end

  assign unlocked = (st_q == KEY_OPEN);

  // R3
  open_needs_second_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_we && key_data == KEY_SECOND));

  // R4
  wrong_key_locks_chk: assert property (@(posedge clk) disable iff (rst)
    (key_we && key_data != KEY_SECOND) |=> !unlocked);
endmodule

// File: rtl/boot_bank_switch.sv
module boot_bank_switch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic loader_req,
  input  logic idle_in,
  input  logic wake_in,
  output logic bank_sel,
  output logic pc_clear
);
  logic idle_seen;
  logic do_wake;

  assign do_wake = wake_in && idle_seen;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idle_seen <= 1'b0;
      bank_sel  <= 1'b0;
      pc_clear  <= 1'b0;
    end else begin
      if (wake_in)
        idle_seen <= 1'b0;
      else if (idle_in)
        idle_seen <= 1'b1;
      pc_clear <= do_wake && (loader_req != bank_sel);
      if (do_wake)
        bank_sel <= loader_req;
    end
  end

  // R5
  bank_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!wake_in && !clr) |=> $stable(bank_sel));

  // R6
  clear_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    pc_clear |-> (bank_sel != $past(bank_sel)));

  // R6
  clear_single_chk: assert property (@(posedge clk) disable iff (rst)
    pc_clear |=> !pc_clear);
endmodule

// File: rtl/boot_addr_map.sv
module boot_addr_map #(
  parameter int CPU_AW       = 16,
  parameter int MAIN_BYTES   = 32768,
  parameter int LOADER_BYTES = 4096,
  localparam int MEM_AW = $clog2(MAIN_BYTES + LOADER_BYTES),
  localparam int MAIN_AW = $clog2(MAIN_BYTES),
  localparam int LDR_AW  = $clog2(LOADER_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_sel,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [MEM_AW-1:0] mem_addr
);
  localparam logic [MEM_AW-1:0] LDR_BASE = MEM_AW'(MAIN_BYTES);

  logic [MEM_AW-1:0] nxt;

  always_comb begin
    if (bank_sel)
      nxt = LDR_BASE + MEM_AW'(cpu_addr[LDR_AW-1:0]);
    else
      nxt = MEM_AW'(cpu_addr[MAIN_AW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) mem_addr <= '0;
    else     mem_addr <= nxt;
  end

  // R8
  loader_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bank_sel) |-> (mem_addr >= LDR_BASE));
endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 2,
  parameter int CPU_AW       = 16,
  parameter int MAIN_BYTES   = 32768,
  parameter int LOADER_BYTES = 4096,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 2'd1,
  parameter logic [DATA_W-1:0] RESET_MASK = 8'h83,
  parameter int LOADER_BIT = 0,
  localparam int MEM_AW = $clog2(MAIN_BYTES + LOADER_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              idle_in,
  input  logic              wake_in,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              bank_sel,
  output logic              pc_clear,
  output logic              soft_rst
);
  logic [DATA_W-1:0] cfg_q;
  logic unlocked;
  logic cfg_wr;
  logic key_wr;
  logic soft_hit;

  assign key_wr   = bus_we && (bus_addr == KEY_ADDR);
  assign cfg_wr   = bus_we && (bus_addr == CFG_ADDR) && unlocked;
  assign soft_hit = cfg_wr && ((bus_wdata & RESET_MASK) == RESET_MASK);

  boot_key_unlock #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst(rst), .clr(soft_hit),
    .key_we(key_wr), .key_data(bus_wdata), .unlocked(unlocked)
  );

  boot_bank_switch u_bank (
    .clk(clk), .rst(rst), .clr(soft_hit),
    .loader_req(cfg_q[LOADER_BIT]), .idle_in(idle_in), .wake_in(wake_in),
    .bank_sel(bank_sel), .pc_clear(pc_clear)
  );

  boot_addr_map #(
    .CPU_AW(CPU_AW), .MAIN_BYTES(MAIN_BYTES), .LOADER_BYTES(LOADER_BYTES)
  ) u_map (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .cpu_addr(cpu_addr), .mem_addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_hit)   cfg_q <= '0;
    else if (cfg_wr)       cfg_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) soft_rst <= 1'b0;
    else     soft_rst <= soft_hit;
  end

  always_ff @(posedge clk) begin
    if (rst)                        rd_data <= '0;
    else if (bus_addr == CFG_ADDR)  rd_data <= cfg_q;
    else if (bus_addr == KEY_ADDR)  rd_data <= DATA_W'(unlocked);
    else                            rd_data <= '0;
  end

  // R2
  locked_cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == CFG_ADDR && unlocked) |=> $stable(cfg_q));

  // R7
  soft_single_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  // R7
  soft_clears_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (!bank_sel && !unlocked && cfg_q == '0));
endmodule

// File: tb/test_boot_mode_ctrl.sv
module test_boot_mode_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] rd_data;
  logic idle_in = 0, wake_in = 0;
  logic [15:0] cpu_addr = 0;
  logic [15:0] mem_addr;
  logic bank_sel, pc_clear, soft_rst;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boot_mode_ctrl i_boot_mode_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .idle_in(idle_in),
    .wake_in(wake_in), .cpu_addr(cpu_addr), .mem_addr(mem_addr),
    .bank_sel(bank_sel), .pc_clear(pc_clear), .soft_rst(soft_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse_idle();
    idle_in = 1; @(negedge clk); idle_in = 0; @(negedge clk);
  endtask

  task automatic pulse_wake();
    wake_in = 1; @(negedge clk); wake_in = 0;
  endtask

  task automatic unlock();
    wr(2'd1, 8'h87); wr(2'd1, 8'h59);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(bank_sel == 0, "R1 bank", bank_sel, 0);
    chk(pc_clear == 0 && soft_rst == 0, "R1 pulses", {pc_clear, soft_rst}, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 cfg", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 key status", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R9 unused addr", v, 0);

    // R3 / R2: every second key byte after 87h
    for (int k = 0; k < 256; k++) begin
      do_reset();
      wr(2'd1, 8'h87); wr(2'd1, 8'(k));
      rd(2'd1, v);
      chk(v == ((k == 'h59) ? 8'h01 : 8'h00), "R3 status after 87h,k", v, (k == 'h59));
      wr(2'd0, 8'h10);
      rd(2'd0, v);
      chk(v == ((k == 'h59) ? 8'h10 : 8'h00), "R2 cfg write gating", v, (k == 'h59) ? 'h10 : 0);
    end

    // R2 / R7: every cfg byte while locked
    for (int c = 0; c < 256; c++) begin
      do_reset();
      wr(2'd0, 8'(c));
      chk(soft_rst == 0, "R7 no pulse when locked", soft_rst, 0);
      rd(2'd0, v);
      chk(v == 8'h00, "R2 locked write ignored", v, 0);
    end

    // R7 / R5: every cfg byte while unlocked
    for (int c = 0; c < 256; c++) begin
      bit hit;
      hit = ((c & 'h83) == 'h83);
      do_reset();
      unlock();
      wr(2'd0, 8'(c));
      chk(soft_rst == hit, "R7 soft pulse", soft_rst, hit);
      chk(bank_sel == 0, "R5 no switch on write", bank_sel, 0);
      rd(2'd0, v);
      chk(v == (hit ? 8'h00 : 8'(c)), "R7 cfg after write", v, hit ? 0 : c);
      chk(soft_rst == 0, "R7 pulse one cycle", soft_rst, 0);
      rd(2'd1, v);
      chk(v == (hit ? 8'h00 : 8'h01), "R7 key status", v, hit ? 0 : 1);
    end

    // R4 orderings
    do_reset();
    wr(2'd1, 8'h59); rd(2'd1, v); chk(v == 0, "R4 59h alone", v, 0);
    wr(2'd1, 8'h33); wr(2'd1, 8'h87); wr(2'd1, 8'h59);
    rd(2'd1, v); chk(v == 1, "R4 restart after wrong", v, 1);
    wr(2'd1, 8'h87); rd(2'd1, v); chk(v == 0, "R4 87h clears open", v, 0);
    wr(2'd1, 8'h59); rd(2'd1, v); chk(v == 1, "R4 reopen", v, 1);
    wr(2'd1, 8'h59); rd(2'd1, v); chk(v == 0, "R4 repeated 59h", v, 0);
    wr(2'd1, 8'h87); wr(2'd1, 8'h87); wr(2'd1, 8'h59);
    rd(2'd1, v); chk(v == 1, "R4 double 87h", v, 1);
    do_reset();
    wr(2'd1, 8'h87); wr(2'd0, 8'h44); wr(2'd1, 8'h59);
    rd(2'd1, v); chk(v == 1, "R3 other-address write between", v, 1);

    // R5 / R6 wake behaviour
    do_reset();
    unlock();
    wr(2'd0, 8'h01);
    pulse_wake();
    chk(bank_sel == 0 && pc_clear == 0, "R5 wake without idle", bank_sel, 0);
    pulse_idle();
    chk(bank_sel == 0, "R5 idle alone", bank_sel, 0);
    pulse_wake();
    chk(bank_sel == 1, "R6 switch to loader", bank_sel, 1);
    chk(pc_clear == 1, "R6 pc clear pulse", pc_clear, 1);
    @(negedge clk);
    chk(pc_clear == 0, "R6 pc clear one cycle", pc_clear, 0);
    pulse_idle(); pulse_wake();
    chk(pc_clear == 0 && bank_sel == 1, "R6 no change no pulse", pc_clear, 0);

    // R8 loader bank mapping
    for (int a = 0; a < 65536; a += 97) begin
      cpu_addr = 16'(a); @(negedge clk);
      chk(mem_addr == 16'(32768 + (a % 4096)), "R8 loader map", mem_addr, 32768 + (a % 4096));
    end

    // R7 reset returns to main bank
    wr(2'd0, 8'h83);
    chk(soft_rst == 1 && bank_sel == 0, "R7 back to main", bank_sel, 0);

    // R8 main bank mapping
    for (int a = 0; a < 65536; a += 89) begin
      cpu_addr = 16'(a); @(negedge clk);
      chk(mem_addr == 16'(a % 32768), "R8 main map", mem_addr, a % 32768);
    end

    // R6 switch back to main via cfg bit cleared
    unlock(); wr(2'd0, 8'h01); pulse_idle(); pulse_wake();
    wr(2'd0, 8'h00); pulse_idle(); pulse_wake();
    chk(bank_sel == 0 && pc_clear == 1, "R6 switch to main", bank_sel, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule